// File: doc/BRIEF.md
# Burst Column Sequencer for a Two-Bank Synchronous DRAM

This block is the burst controller in front of a two-bank synchronous DRAM core. Each bank holds 131072 words of 32 bits. A mode-set command loads the burst length, the burst order and the read latency from the address bus. Read and write commands then start a burst, and the block issues one column address per clock.

The column order can be sequential or interleaved. Sequential order wraps inside the block that is aligned to the burst length. Interleaved order XORs the beat count into the low bits of the starting column. A full-page burst walks the whole 256-column row, wraps around it and runs until a burst stop or a precharge command ends it.

For reads, the block flags valid data after the programmed latency and applies the byte masks two clocks after they are sampled. For writes, it gives a strobe and byte enables in the same cycle. The cell array and refresh are outside this block.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `burst_o`, `wr_stb_o` and `rd_valid_o` are low, and `wr_be_o` and `rd_be_o` are zero. The mode after reset is burst length 1, sequential order, latency 2 and burst writes.
- R2: A mode-set command (`{cs_n,ras_n,cas_n,we_n}` = 0000) loads the mode from `addr`:
  - `addr[2:0]` is the length code: 000=1, 001=2, 010=4, 011=8, 111=full page; any other code means length 1.
  - `addr[3]` set selects interleaved order.
  - `addr[6:4]` = 011 selects latency 3; any other value selects latency 2.
  - `addr[9]` set selects single-location writes.
  - The command is ignored while `burst_o` is high or when `addr[8:7]` is not zero.
- R3: A read (0101) or write (0100) command makes `burst_o` high in the next cycle, with `col_o` = `addr[7:0]` and `bank_o` = `ba`. One column follows per cycle, and `burst_o` stays high for exactly L cycles.
- R4: In sequential order, beat i addresses column `(start & ~(L-1)) | ((start+i) mod L)`.
- R5: In interleaved order, beat i addresses column `(start & ~(L-1)) | ((start mod L) XOR i)`.
- R6: A full-page burst steps through the columns as (start+i) mod 256 and runs until it is stopped. The interleave bit has no effect on a full-page burst.
- R7: A burst stop (0110) or precharge (0010) command drops `burst_o` in the next cycle.
- R8: A read or write command that arrives during a burst abandons the current burst. The new sequence starts from its own column in the next cycle.
- R9: `rd_valid_o` is high for each read beat, 1 cycle (latency 2) or 2 cycles (latency 3) after that beat's column is shown on `col_o`.
- R10: While `rd_valid_o` is high, `rd_be_o` is the inverse of `dqm` sampled two clock edges earlier. Otherwise `rd_be_o` is zero.
- R11: During a write beat, `wr_stb_o` is high and `wr_be_o` is the inverse of the present `dqm`, with no register delay. Outside write beats both are zero.
- R12: With single-location writes selected, a write lasts exactly one beat. Reads still use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe of the command code |
| cas_n | input | 1 | Column strobe of the command code |
| we_n | input | 1 | Write-enable bit of the command code |
| addr | input | ADDR_W (10) | Start column (low 8 bits) or mode key |
| ba | input | BANK_W (1) | Bank select |
| dqm | input | BYTES (4) | Byte masks, 1 masks the byte |
| col_o | output | COL_W (8) | Column address of the current beat |
| bank_o | output | BANK_W (1) | Bank of the current burst |
| burst_o | output | 1 | A burst beat is being issued |
| wr_stb_o | output | 1 | Write beat strobe |
| wr_be_o | output | BYTES (4) | Write byte enables |
| rd_valid_o | output | 1 | Read data valid |
| rd_be_o | output | BYTES (4) | Read byte enables |

## Verification
The bench runs these corner cases, each against the failure it would expose:
- Odd starting columns, to catch a design that wraps across the length-aligned block, or that adds where it should XOR.
- A full-page burst across column 255, to catch a design that stops at the row end or that lets the interleave bit in.
- A command that cuts a burst short, to catch one that keeps the old counter.
- A mode-set command sent mid-burst, to catch one that changes its length or latency halfway.
- Byte masks that change on every beat, to tell a one-cycle or zero-cycle mask path from the two-cycle read path and the same-cycle write path.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 8,
  parameter int BANK_W = 1,
  parameter int BYTES  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] ba,
  input  logic [BYTES-1:0]  dqm,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              burst_o,
  output logic              wr_stb_o,
  output logic [BYTES-1:0]  wr_be_o,
  output logic              rd_valid_o,
  output logic [BYTES-1:0]  rd_be_o
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  wire cmd_mode = ~cs_n & ~ras_n & ~cas_n & ~we_n;
  wire cmd_rd   = ~cs_n &  ras_n & ~cas_n &  we_n;
  wire cmd_wr   = ~cs_n &  ras_n & ~cas_n & ~we_n;
  wire cmd_stop = ~cs_n &  ras_n &  cas_n & ~we_n;
  wire cmd_pre  = ~cs_n & ~ras_n &  cas_n & ~we_n;

  logic [2:0]        len_code_q;
  logic              ilv_q, lat3_q, single_q;
  logic              active_q, is_wr_q;
  logic [COL_W-1:0]  start_q, beat_q;
  logic [BANK_W-1:0] bank_q;
  logic              rv1_q, rv2_q;
  logic [BYTES-1:0]  msk1_q, msk2_q;
  logic [COL_W-1:0]  len_mask;

  always_comb begin
    case (len_code_q)
      3'b001:  len_mask = COL_W'(1);
      3'b010:  len_mask = COL_W'(3);
      3'b011:  len_mask = COL_W'(7);
      3'b111:  len_mask = ALL_ONES;
      default: len_mask = '0;
    endcase
  end

  wire              one_beat = is_wr_q & single_q;
  wire              full_pg  = (len_code_q == 3'b111) & ~one_beat;
  wire [COL_W-1:0]  eff_mask = one_beat ? '0 : len_mask;
  wire [COL_W-1:0]  offset   = (ilv_q & ~full_pg) ? (start_q ^ beat_q) : (start_q + beat_q);
  wire              last     = ~full_pg & (beat_q == eff_mask);

  assign col_o      = (start_q & ~eff_mask) | (offset & eff_mask);
  assign bank_o     = bank_q;
  assign burst_o    = active_q;
  assign wr_stb_o   = active_q & is_wr_q;
  assign wr_be_o    = wr_stb_o ? ~dqm : '0;
  assign rd_valid_o = lat3_q ? rv2_q : rv1_q;
  assign rd_be_o    = rd_valid_o ? ~msk2_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_code_q <= 3'b000;
      ilv_q      <= 1'b0;
      lat3_q     <= 1'b0;
      single_q   <= 1'b0;
      active_q   <= 1'b0;
      is_wr_q    <= 1'b0;
      start_q    <= '0;
      beat_q     <= '0;
      bank_q     <= '0;
      rv1_q      <= 1'b0;
      rv2_q      <= 1'b0;
      msk1_q     <= '0;
      msk2_q     <= '0;
    end else begin
      rv1_q  <= active_q & ~is_wr_q;
      rv2_q  <= rv1_q;
      msk1_q <= dqm;
      msk2_q <= msk1_q;
      if (cmd_rd || cmd_wr) begin
        active_q <= 1'b1;
        is_wr_q  <= cmd_wr;
        start_q  <= addr[COL_W-1:0];
        beat_q   <= '0;
        bank_q   <= ba;
      end else if (cmd_stop || cmd_pre) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (last) active_q <= 1'b0;
        else      beat_q   <= beat_q + 1'b1;
      end
      if (cmd_mode && !active_q && addr[8:7] == 2'b00) begin
        len_code_q <= addr[2:0];
        ilv_q      <= addr[3];
        lat3_q     <= (addr[6:4] == 3'b011);
        single_q   <= addr[9];
      end
    end
  end

  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |=> burst_o && col_o == $past(addr[COL_W-1:0]) && bank_o == $past(ba)); // R3
  AST_BURST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_stop || cmd_pre) && !cmd_rd && !cmd_wr) |=> !burst_o); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    burst_o |=> $stable({len_code_q, ilv_q, lat3_q, single_q})); // R2
  AST_READ_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_o && !wr_stb_o && !lat3_q) |=> rd_valid_o); // R9
  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> rd_be_o == ~$past(dqm, 2)); // R10
  AST_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_o |-> !wr_stb_o && wr_be_o == '0); // R11
endmodule

// File: tb/sdram_burst_seq_bench.sv
`timescale 1ns/1ps
module sdram_burst_seq_bench;
  localparam logic [3:0] C_NOP = 4'b0111, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_MODE = 4'b0000, C_STOP = 4'b0110, C_PRE = 4'b0010;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, ras_n, cas_n, we_n;
  logic [9:0] addr;
  logic [0:0] ba;
  logic [3:0] dqm;
  logic [7:0] col_o;
  logic [0:0] bank_o;
  logic burst_o, wr_stb_o, rd_valid_o;
  logic [3:0] wr_be_o, rd_be_o;

  sdram_burst_seq u_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .dqm(dqm), .col_o(col_o), .bank_o(bank_o), .burst_o(burst_o),
    .wr_stb_o(wr_stb_o), .wr_be_o(wr_be_o), .rd_valid_o(rd_valid_o), .rd_be_o(rd_be_o));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input int a, input int b, input logic [3:0] m);
    {cs_n, ras_n, cas_n, we_n} = c;
    addr = 10'(a); ba = 1'(b); dqm = m;
    @(posedge clk); @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
  endtask

  function automatic int exp_col(input int start, input int i, input int len, input bit ilv);
    int base;
    if (len >= 256) return (start + i) % 256;
    base = start - (start % len);
    if (ilv) return base | ((start % len) ^ (i % len));
    return base | ((start + i) % len);
  endfunction

  task automatic set_mode(input int code, input bit ilv, input int lat, input bit single);
    step(C_MODE, (int'(single) << 9) | ((lat & 7) << 4) | (int'(ilv) << 3) | (code & 7), 0, 4'h0);
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) step(C_NOP, 0, 0, 4'h0);
  endtask

  task automatic t_reset;
    chk(!burst_o && !wr_stb_o && !rd_valid_o, "R1 idle flags", longint'({burst_o, wr_stb_o, rd_valid_o}), 0);
    chk(wr_be_o == 4'h0 && rd_be_o == 4'h0, "R1 enables zero", longint'({wr_be_o, rd_be_o}), 0);
    step(C_RD, 5, 0, 4'h0);
    chk(burst_o && col_o == 8'd5, "R1 default length beat0", longint'(col_o), 5);
    step(C_NOP, 0, 0, 4'h0);
    chk(!burst_o, "R1 default length 1", longint'(burst_o), 0);
    chk(rd_valid_o, "R1 default latency 2", longint'(rd_valid_o), 1);
    step(C_NOP, 0, 0, 4'h0);
    chk(!rd_valid_o, "R1 single read beat", longint'(rd_valid_o), 0);
    drain(2);
  endtask

  task automatic t_read(input string tag, input int code, input int len, input bit ilv,
                        input int lat, input int start, input int b);
    set_mode(code, ilv, lat, 1'b0);
    step(C_RD, start, b, 4'h0);
    chk(bank_o == 1'(b), "R3 bank", longint'(bank_o), longint'(b));
    for (int j = 0; j < len + lat + 1; j++) begin
      chk(burst_o == (j < len), "R3 burst length", longint'(burst_o), longint'(j < len));
      if (j < len)
        chk(col_o == 8'(exp_col(start, j, len, ilv)), tag, longint'(col_o),
            longint'(exp_col(start, j, len, ilv)));
      chk(rd_valid_o == (j >= lat - 1 && j < lat - 1 + len), "R9 read valid timing",
          longint'(rd_valid_o), longint'(j >= lat - 1 && j < lat - 1 + len));
      step(C_NOP, 0, 0, 4'h0);
    end
  endtask

  task automatic t_full_page;
    set_mode(7, 1'b1, 2, 1'b0);
    step(C_RD, 254, 0, 4'h0);
    for (int j = 0; j < 260; j++) begin
      chk(burst_o && col_o == 8'((254 + j) % 256), "R6 full page column", longint'(col_o),
          longint'((254 + j) % 256));
      if (j < 259) step(C_NOP, 0, 0, 4'h0);
      else step(C_STOP, 0, 0, 4'h0);
    end
    chk(!burst_o, "R7 burst stop", longint'(burst_o), 0);
    drain(3);
    set_mode(3, 1'b0, 2, 1'b0);
    step(C_RD, 0, 0, 4'h0);
    drain(2);
    step(C_PRE, 0, 0, 4'h0);
    chk(!burst_o, "R7 precharge stop", longint'(burst_o), 0);
    drain(3);
  endtask

  task automatic t_interrupt;
    set_mode(3, 1'b0, 2, 1'b0);
    step(C_RD, 32'h20, 0, 4'h0);
    for (int j = 0; j < 3; j++) begin
      chk(col_o == 8'(32'h20 + j), "R8 first burst", longint'(col_o), longint'(32'h20 + j));
      if (j < 2) step(C_NOP, 0, 0, 4'h0);
      else step(C_RD, 32'h45, 1, 4'h0);
    end
    for (int i = 0; i < 8; i++) begin
      chk(burst_o && col_o == 8'(exp_col(32'h45, i, 8, 1'b0)), "R8 new burst column",
          longint'(col_o), longint'(exp_col(32'h45, i, 8, 1'b0)));
      step(C_NOP, 0, 0, 4'h0);
    end
    chk(!burst_o, "R8 new burst full length", longint'(burst_o), 0);
    drain(3);
  endtask

  task automatic t_write;
    logic [3:0] pat [4] = '{4'b0000, 4'b0101, 4'b1000, 4'b1111};
    set_mode(2, 1'b0, 3, 1'b0);
    step(C_WR, 32'h13, 0, 4'h0);
    for (int j = 0; j < 4; j++) begin
      dqm = pat[j];
      #0.5;
      chk(wr_stb_o && wr_be_o == ~pat[j], "R11 write enables", longint'(wr_be_o), longint'(~pat[j]));
      chk(col_o == 8'(exp_col(32'h13, j, 4, 1'b0)), "R4 write column", longint'(col_o),
          longint'(exp_col(32'h13, j, 4, 1'b0)));
      chk(!rd_valid_o, "R9 no read valid on writes", longint'(rd_valid_o), 0);
      step(C_NOP, 0, 0, pat[j]);
    end
    chk(!wr_stb_o && wr_be_o == 4'h0, "R11 write ended", longint'(wr_be_o), 0);
    drain(3);
  endtask

  task automatic t_single_write;
    set_mode(3, 1'b0, 2, 1'b1);
    step(C_WR, 32'h30, 0, 4'h0);
    chk(wr_stb_o && col_o == 8'h30, "R12 single write beat", longint'(col_o), 32'h30);
    step(C_NOP, 0, 0, 4'h0);
    chk(!burst_o && !wr_stb_o, "R12 write one beat", longint'(burst_o), 0);
    drain(2);
    step(C_RD, 32'h30, 0, 4'h0);
    for (int j = 0; j < 8; j++) begin
      chk(burst_o, "R12 read keeps length", longint'(burst_o), 1);
      step(C_NOP, 0, 0, 4'h0);
    end
    chk(!burst_o, "R12 read ends at 8", longint'(burst_o), 0);
    drain(3);
  endtask

  task automatic t_read_mask;
    logic [3:0] d [6] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1010, 4'b0101};
    set_mode(2, 1'b0, 2, 1'b0);
    step(C_RD, 0, 0, d[0]);
    for (int k = 1; k < 6; k++) begin
      step(C_NOP, 0, 0, d[k]);
      chk(rd_be_o == ((k <= 4) ? ~d[k-1] : 4'h0), "R10 read mask latency", longint'(rd_be_o),
          longint'((k <= 4) ? ~d[k-1] : 4'h0));
    end
    drain(3);
  endtask

  task automatic t_mode_guard;
    set_mode(3, 1'b0, 2, 1'b0);
    step(C_RD, 0, 0, 4'h0);
    set_mode(0, 1'b0, 3, 1'b0);
    drain(10);
    step(C_MODE, (1 << 7) | (3 << 4), 0, 4'h0);
    step(C_RD, 0, 0, 4'h0);
    chk(!rd_valid_o, "R2 latency kept", longint'(rd_valid_o), 0);
    step(C_NOP, 0, 0, 4'h0);
    chk(rd_valid_o, "R2 mode ignored while busy (latency 2)", longint'(rd_valid_o), 1);
    for (int j = 1; j < 8; j++) begin
      chk(burst_o, "R2 length 8 kept", longint'(burst_o), 1);
      step(C_NOP, 0, 0, 4'h0);
    end
    chk(!burst_o, "R2 burst ends at 8", longint'(burst_o), 0);
    drain(3);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; {cs_n, ras_n, cas_n, we_n} = C_NOP; addr = '0; ba = '0; dqm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read("R4 sequential L4", 2, 4, 1'b0, 2, 6, 1);
    t_read("R5 interleave L8", 3, 8, 1'b1, 3, 5, 0);
    t_read("R4 sequential L2", 1, 2, 1'b0, 3, 3, 1);
    t_read("R5 interleave L4", 2, 4, 1'b1, 2, 32'h9e, 0);
    t_full_page();
    t_interrupt();
    t_write();
    t_single_write();
    t_read_mask();
    t_mode_guard();
    finished = 1'b1;
    summary();
  end
endmodule